// File: doc/BRIEF.md
# Harmonic-Free Delay-Line Lock Controller

This block is the digital control loop of an all-digital multiphase delay-locked loop. It drives a tuning word to an external digitally controlled delay line. The word has three cascaded fields: a range field that scales the delay line's unit delay, a coarse field and a fine field. The delay seen by the reference clock is `(coarse*2^FIN_W + fine) * unit * 2^range`. The nominal reference period of every range therefore sits at the middle of the tuning code, `2^(CRS_W+FIN_W-1)`.

After reset the controller is in the estimation state `PH_EST`. It raises `est_en` so that an external frequency estimator can measure the reference clock. It then takes the 2-bit range code returned with `freq_code_vld` into the range field and moves to `PH_COARSE` (transition T1). In coarse acquisition, every detector decision (`pd_vld`, with `pd_up` meaning "delay too short") moves the coarse field by one. Two consecutive direction reversals move it to `PH_FINE` (T2). In fine acquisition, each decision moves the combined coarse/fine code by one LSB, with carry and borrow between the two fields. Two further consecutive reversals move it to `PH_LOCK` (T3). `PH_LOCK` raises `lock_done` and keeps making narrow corrections so that the loop follows slow drift. Only reset leaves `PH_LOCK`.

Throughout all of this the tuning code is held strictly inside half to one-and-a-half nominal periods. The loop therefore can never settle on a multiple of the period.

Top module: `dll_lock_ctrl`

## Requirements
- R1: After reset, `est_en`=1, `lock_done`=0, the range field is 0, the tuning code `{dl_coarse,dl_fine}` equals TLO = 2^(TW-2)+1 with TW = CRS_W+FIN_W, and all four step strobes are 0.
- R2: While `est_en`=1, a cycle with `freq_code_vld`=1 loads `freq_code` into `dl_range` and clears `est_en` on the next cycle. Later `freq_code_vld` pulses leave `dl_range` unchanged.
- R3: Detector decisions made while `est_en`=1 change neither the tuning code nor the strobes.
- R4: In coarse acquisition, each decision changes the tuning code by 2^FIN_W (up when `pd_up`=1) and pulses `stp_wide_up` or `stp_wide_dn` in the cycle after the decision.
- R5: A reversal is a decision whose direction differs from the previous decision in the same acquisition run. When a decision makes two reversals in a row, acquisition switches from wide to narrow steps for the following decisions.
- R6: Narrow steps change the tuning code by exactly 1 and pulse `stp_nar_up` or `stp_nar_dn`. The fine field carries into and borrows from the coarse field.
- R7: The tuning code always stays in [TLO, THI], where THI = 3*2^(TW-2)-1. A step that would leave this range is dropped: the code holds and no strobe pulses.
- R8: In narrow acquisition, a decision that makes two reversals in a row sets `lock_done`, which then stays 1 until reset.
- R9: After lock, decisions keep producing narrow steps, so the code follows a moved target while `lock_done` stays 1.
- R10: For any target at least one wide step inside the range, lock is reached in fewer than 200 decisions.
- R11: At most one strobe is high in any cycle. A strobe only pulses in the cycle after a decision, and strobes are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_code | input | RNG_W | Range code from the frequency estimator |
| freq_code_vld | input | 1 | `freq_code` is valid this cycle |
| pd_vld | input | 1 | Detector decision present this cycle |
| pd_up | input | 1 | 1: delay too short, lengthen; 0: shorten |
| est_en | output | 1 | Enable for the frequency estimator |
| dl_range | output | RNG_W | Range-select field of the tuning word |
| dl_coarse | output | CRS_W | Coarse-tuning field |
| dl_fine | output | FIN_W | Fine-tuning field |
| stp_wide_up | output | 1 | Wide step toward more delay applied |
| stp_nar_up | output | 1 | Narrow step toward more delay applied |
| stp_wide_dn | output | 1 | Wide step toward less delay applied |
| stp_nar_dn | output | 1 | Narrow step toward less delay applied |
| lock_done | output | 1 | Lock reached (sticky until reset) |

## Verification
The bench drives the loop with a modelled delay line and detector, and checks every decision against a reference model. It covers the wide-to-narrow switch and the narrow-to-lock switch; a design that counted single reversals or reset its count wrongly would change phase one decision early or late. Narrow stepping across a coarse boundary (63↔64) is exercised in both directions; a design that dropped the carry or borrow would jump by a full coarse step. Targets far above and far below the window push the code against both limits; a design that clamped or wrapped instead of dropping the step would leave the window or pulse a strobe. Range codes and decisions given in the wrong state must be ignored; a design that failed this would drift during estimation or be re-ranged while locked.

// File: rtl/dll_ctl_pkg.sv
`timescale 1ns/1ps
package dll_ctl_pkg;

    typedef enum logic [1:0] {
        PH_EST    = 2'd0,
        PH_COARSE = 2'd1,
        PH_FINE   = 2'd2,
        PH_LOCK   = 2'd3
    } lock_phase_e;

    typedef enum logic [1:0] {
        STP_NONE   = 2'd0,
        STP_WIDE   = 2'd1,
        STP_NARROW = 2'd2
    } step_size_e;

    typedef struct packed {
        logic wide_up;
        logic nar_up;
        logic wide_dn;
        logic nar_dn;
    } step_strobe_t;

endpackage

// File: rtl/dll_rev_tracker.sv
`timescale 1ns/1ps
// Counts consecutive direction reversals of detector decisions.
module dll_rev_tracker #(
    parameter int REV_NEED = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic vld,
    input  logic dir,
    output logic hit
);
    localparam int CNTW = (REV_NEED < 2) ? 1 : $clog2(REV_NEED + 1);
    localparam logic [CNTW-1:0] LAST_C = CNTW'(REV_NEED - 1);

    logic            last_dir;
    logic            have_last;
    logic [CNTW-1:0] rev_cnt;
    logic            is_rev;

    always_comb begin
        is_rev = have_last && (dir != last_dir);
        hit    = vld && is_rev && (rev_cnt == LAST_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_dir  <= 1'b0;
            have_last <= 1'b0;
            rev_cnt   <= '0;
        end else if (clr) begin
            have_last <= 1'b0;
            rev_cnt   <= '0;
        end else if (vld) begin
            last_dir  <= dir;
            have_last <= 1'b1;
            rev_cnt   <= (!is_rev || hit) ? '0 : rev_cnt + 1'b1;
        end
    end

    // R5: the run count never reaches the switch threshold as stored state
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rev_cnt <= LAST_C);

    // R5: a non-reversal decision restarts the run
    p_run_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !clr && !is_rev) |=> (rev_cnt == '0));

endmodule

// File: rtl/dll_step_unit.sv
`timescale 1ns/1ps
// Holds the coarse/fine tuning code and applies window-limited steps.
module dll_step_unit
    import dll_ctl_pkg::*;
#(
    parameter int CRS_W = 4,
    parameter int FIN_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step_req,
    input  logic                   step_up,
    input  step_size_e             step_size,
    output logic [CRS_W+FIN_W-1:0] tune,
    output step_strobe_t           strb
);
    localparam int TW    = CRS_W + FIN_W;
    localparam int NCODE = 1 << TW;
    localparam logic [TW:0] LO_C   = (TW+1)'(NCODE / 4 + 1);
    localparam logic [TW:0] HI_C   = (TW+1)'(3 * NCODE / 4 - 1);
    localparam logic [TW:0] WIDE_C = (TW+1)'(1 << FIN_W);
    localparam logic [TW:0] ONE_C  = (TW+1)'(1);

    logic [TW:0] delta;
    logic [TW:0] cand;
    logic        in_win;
    logic        take;
    logic        is_wide;

    always_comb begin
        is_wide = (step_size == STP_WIDE);
        delta   = is_wide ? WIDE_C : ONE_C;
        cand    = step_up ? ({1'b0, tune} + delta) : ({1'b0, tune} - delta);
        in_win  = (cand >= LO_C) && (cand <= HI_C);
        take    = step_req && (step_size != STP_NONE) && in_win;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tune <= LO_C[TW-1:0];
            strb <= '0;
        end else begin
            strb <= '0;
            if (take) begin
                tune         <= cand[TW-1:0];
                strb.wide_up <= is_wide && step_up;
                strb.nar_up  <= !is_wide && step_up;
                strb.wide_dn <= is_wide && !step_up;
                strb.nar_dn  <= !is_wide && !step_up;
            end
        end
    end

    // R7: code never leaves the allowed window
    p_tune_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, tune} >= LO_C) && ({1'b0, tune} <= HI_C));

    // R11: one strobe at most, only after a request
    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb));
    p_strobe_after_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (strb != '0) |-> $past(step_req));

    // R4: a wide up step moves the code by one coarse unit
    p_wide_up_delta_r4: assert property (@(posedge clk) disable iff (!rst_n)
        strb.wide_up |-> ({1'b0, tune} == {1'b0, $past(tune)} + WIDE_C));

    // R6: a narrow down step moves the code by one LSB with borrow
    p_nar_dn_delta_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strb.nar_dn |-> ({1'b0, tune} + ONE_C == {1'b0, $past(tune)}));

    // R7: no strobe means the code held
    p_quiet_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strb == '0) |-> $stable(tune));

endmodule

// File: rtl/dll_lock_fsm.sv
`timescale 1ns/1ps
// Lock sequencing: estimate -> coarse -> fine -> lock.
module dll_lock_fsm
    import dll_ctl_pkg::*;
#(
    parameter int RNG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RNG_W-1:0] code_in,
    input  logic             code_vld,
    input  logic             pd_vld,
    input  logic             rev_hit,
    output logic             est_en,
    output logic [RNG_W-1:0] range_sel,
    output logic             done,
    output logic             trk_clr,
    output logic             step_req,
    output step_size_e       step_size
);
    lock_phase_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_EST:    if (code_vld) state_d = PH_COARSE;
            PH_COARSE: if (rev_hit)  state_d = PH_FINE;
            PH_FINE:   if (rev_hit)  state_d = PH_LOCK;
            PH_LOCK:   state_d = PH_LOCK;
            default:   state_d = PH_EST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= PH_EST;
            range_sel <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == PH_EST && code_vld) range_sel <= code_in;
        end
    end

    always_comb begin
        est_en    = 1'b0;
        done      = 1'b0;
        trk_clr   = 1'b0;
        step_req  = 1'b0;
        step_size = STP_NONE;
        unique case (state_q)
            PH_EST: begin
                est_en  = 1'b1;
                trk_clr = 1'b1;
            end
            PH_COARSE: begin
                step_req  = pd_vld;
                step_size = STP_WIDE;
            end
            PH_FINE: begin
                step_req  = pd_vld;
                step_size = STP_NARROW;
            end
            PH_LOCK: begin
                done      = 1'b1;
                step_req  = pd_vld;
                step_size = STP_NARROW;
            end
            default: begin
                est_en = 1'b0;
            end
        endcase
    end

    // R8: lock flag is sticky
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R2: range field frozen once estimation is over
    p_range_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!est_en && !$past(est_en)) |-> $stable(range_sel));

    // R2: estimation ends only on an accepted code
    p_est_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(est_en) |-> $past(code_vld));

endmodule

// File: rtl/dll_lock_ctrl.sv
`timescale 1ns/1ps
module dll_lock_ctrl
    import dll_ctl_pkg::*;
#(
    parameter int RNG_W    = 2,
    parameter int CRS_W    = 4,
    parameter int FIN_W    = 3,
    parameter int REV_NEED = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RNG_W-1:0] freq_code,
    input  logic             freq_code_vld,
    input  logic             pd_vld,
    input  logic             pd_up,
    output logic             est_en,
    output logic [RNG_W-1:0] dl_range,
    output logic [CRS_W-1:0] dl_coarse,
    output logic [FIN_W-1:0] dl_fine,
    output logic             stp_wide_up,
    output logic             stp_nar_up,
    output logic             stp_wide_dn,
    output logic             stp_nar_dn,
    output logic             lock_done
);
    localparam int TW = CRS_W + FIN_W;

    logic         rev_hit;
    logic         trk_clr;
    logic         step_req;
    step_size_e   step_size;
    logic [TW-1:0] tune;
    step_strobe_t strb;

    dll_lock_fsm #(.RNG_W(RNG_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_in   (freq_code),
        .code_vld  (freq_code_vld),
        .pd_vld    (pd_vld),
        .rev_hit   (rev_hit),
        .est_en    (est_en),
        .range_sel (dl_range),
        .done      (lock_done),
        .trk_clr   (trk_clr),
        .step_req  (step_req),
        .step_size (step_size)
    );

    dll_rev_tracker #(.REV_NEED(REV_NEED)) u_rev (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (trk_clr),
        .vld   (step_req),
        .dir   (pd_up),
        .hit   (rev_hit)
    );

    dll_step_unit #(.CRS_W(CRS_W), .FIN_W(FIN_W)) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_req  (step_req),
        .step_up   (pd_up),
        .step_size (step_size),
        .tune      (tune),
        .strb      (strb)
    );

    assign dl_coarse   = tune[TW-1:FIN_W];
    assign dl_fine     = tune[FIN_W-1:0];
    assign stp_wide_up = strb.wide_up;
    assign stp_nar_up  = strb.nar_up;
    assign stp_wide_dn = strb.wide_dn;
    assign stp_nar_dn  = strb.nar_dn;

    // R3: decisions during estimation leave the code alone
    p_est_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (est_en && $past(est_en)) |-> $stable(tune));

    // R9: after lock only narrow steps occur
    p_lock_narrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_done && $past(lock_done)) |-> !(stp_wide_up || stp_wide_dn));

endmodule

// File: tb/test_dll_lock_ctrl.sv
`timescale 1ns/1ps
module test_dll_lock_ctrl;
    localparam int RNG_W = 2;
    localparam int CRS_W = 4;
    localparam int FIN_W = 3;
    localparam int TW    = CRS_W + FIN_W;
    localparam int NCODE = 1 << TW;
    localparam int TLO   = NCODE / 4 + 1;
    localparam int THI   = 3 * NCODE / 4 - 1;
    localparam int WIDE  = 1 << FIN_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [RNG_W-1:0] freq_code = '0;
    logic             freq_code_vld = 1'b0;
    logic             pd_vld = 1'b0;
    logic             pd_up = 1'b0;
    logic             est_en;
    logic [RNG_W-1:0] dl_range;
    logic [CRS_W-1:0] dl_coarse;
    logic [FIN_W-1:0] dl_fine;
    logic             stp_wide_up, stp_nar_up, stp_wide_dn, stp_nar_dn;
    logic             lock_done;

    always #2.5 clk = ~clk;

    dll_lock_ctrl i_dll_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .freq_code(freq_code), .freq_code_vld(freq_code_vld),
        .pd_vld(pd_vld), .pd_up(pd_up), .est_en(est_en), .dl_range(dl_range),
        .dl_coarse(dl_coarse), .dl_fine(dl_fine), .stp_wide_up(stp_wide_up),
        .stp_nar_up(stp_nar_up), .stp_wide_dn(stp_wide_dn), .stp_nar_dn(stp_nar_dn),
        .lock_done(lock_done)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference model state
    int m_t;
    int m_phase;   // 0 estimate, 1 coarse, 2 fine, 3 lock
    bit m_last;
    bit m_have;
    int m_cnt;
    int n_dec;

    logic [TW+4:0] exp_q[$];
    string         tag_q[$];

    function automatic int tune_now();
        return int'({dl_coarse, dl_fine});
    endfunction

    function automatic logic [3:0] strobes_now();
        return {stp_wide_up, stp_nar_up, stp_wide_dn, stp_nar_dn};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor: one item per decision, sampled after the edge
    always @(posedge clk) begin
        if (rst_n && pd_vld) begin
            #1;
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R11: actual=unexpected decision result expected=none");
            end else begin
                logic [TW+4:0] e;
                logic [TW+4:0] a;
                string         tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                a  = {dl_coarse, dl_fine, strobes_now(), lock_done};
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual code=%0d strb=%b done=%b expected code=%0d strb=%b done=%b",
                             tg, a[TW+4:5], a[4:1], a[0], e[TW+4:5], e[4:1], e[0]);
                end
            end
        end
    end

    task automatic model_reset();
        m_t = TLO; m_phase = 0; m_last = 1'b0; m_have = 1'b0; m_cnt = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pd_vld = 1'b0;
        freq_code_vld = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic accept_code(input logic [RNG_W-1:0] code);
        @(negedge clk);
        freq_code = code;
        freq_code_vld = 1'b1;
        @(negedge clk);
        freq_code_vld = 1'b0;
        if (m_phase == 0) begin
            m_phase = 1; m_have = 1'b0; m_cnt = 0;
        end
    endtask

    // driver: compute expectation, push it, then issue the decision
    task automatic decide(input bit up);
        logic [3:0] es;
        int         nt;
        int         stp;
        string      tg;
        bit         rv;
        es = 4'b0000;
        tg = "R3";
        if (m_phase != 0) begin
            stp = (m_phase == 1) ? WIDE : 1;
            nt  = up ? m_t + stp : m_t - stp;
            tg  = (m_phase == 1) ? "R4" : ((m_phase == 2) ? "R6" : "R9");
            if (nt >= TLO && nt <= THI) begin
                m_t = nt;
                es = {m_phase == 1 && up, m_phase != 1 && up,
                      m_phase == 1 && !up, m_phase != 1 && !up};
            end else begin
                tg = "R7";
            end
            rv = m_have && (up != m_last);
            m_cnt = rv ? m_cnt + 1 : 0;
            m_last = up;
            m_have = 1'b1;
            if (m_cnt == 2) begin
                m_cnt = 0;
                if (m_phase == 1) begin m_phase = 2; tg = "R5"; end
                else if (m_phase == 2) begin m_phase = 3; tg = "R8"; end
            end
        end
        exp_q.push_back({m_t[TW-1:0], es, m_phase == 3});
        tag_q.push_back(tg);
        @(negedge clk);
        pd_vld = 1'b1;
        pd_up = up;
        @(negedge clk);
        pd_vld = 1'b0;
        n_dec++;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int tgt;
        model_reset();
        do_reset();
        @(negedge clk);
        // R1 reset state
        check("R1 est_en", int'(est_en), 1);
        check("R1 lock_done", int'(lock_done), 0);
        check("R1 range", int'(dl_range), 0);
        check("R1 code", tune_now(), TLO);
        check("R1 strobes", int'(strobes_now()), 0);

        // R3 decisions ignored while estimating
        decide(1'b1);
        decide(1'b0);
        check("R3 code after decisions", tune_now(), TLO);
        check("R3 est_en held", int'(est_en), 1);

        // R2 range accepted
        accept_code(2'd2);
        check("R2 est_en cleared", int'(est_en), 0);
        check("R2 range loaded", int'(dl_range), 2);

        // acquire target 60 (crosses 63/64 boundary on the way down)
        tgt = 60;
        n_dec = 0;
        for (int i = 0; i < 250 && !lock_done; i++) decide(tune_now() < tgt);
        check("R8 locked", int'(lock_done), 1);
        check("R10 decisions under 200", int'(n_dec < 200), 1);
        check("R8 code near target", int'(tune_now() >= tgt - 1 && tune_now() <= tgt), 1);

        // R11 strobes idle with no decision
        @(negedge clk);
        check("R11 strobes idle", int'(strobes_now()), 0);

        // R9 tracking after lock, crossing 63->64 upward (R6 carry)
        tgt = 70;
        for (int i = 0; i < 20; i++) decide(tune_now() < tgt);
        check("R9 still locked", int'(lock_done), 1);
        check("R9 followed target", int'(tune_now() >= tgt - 1 && tune_now() <= tgt), 1);

        // R2 late code ignored
        accept_code(2'd1);
        check("R2 range kept", int'(dl_range), 2);

        // R7 upper limit
        do_reset();
        accept_code(2'd1);
        check("R2 range reloaded", int'(dl_range), 1);
        for (int i = 0; i < 12; i++) decide(1'b1);
        check("R7 upper stop", tune_now(), TLO + ((THI - TLO) / WIDE) * WIDE);
        // R7 lower limit
        for (int i = 0; i < 12; i++) decide(1'b0);
        check("R7 lower stop", tune_now(), TLO);
        @(negedge clk);
        check("R7 no strobe at limit", int'(strobes_now()), 0);

        repeat (3) @(negedge clk);
        check("R11 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule